// File: doc/BRIEF.md
# Two-Channel Drive Interrupt Gate

This block sits between two raw drive interrupt lines and the single interrupt line of the card. Each channel owns a one-bit arming latch. The host changes that latch through a byte-wide register port by the kind of access it makes, and the value it writes plays no part. Writing a channel's gate register arms the channel. Reading the same register disarms it. The card interrupt is the OR of every armed channel's raw line, held in one flop.

Each channel also has a status register. It shows the raw line in bit 0 whether the channel is armed or not. A combinational pending output ORs the raw lines, so the host can tell whether any drive wants service. To steer the interrupt to one drive, software writes that drive's gate register and reads the other channel's gate register on the next cycle. A build-time parameter selects a one-channel variant, which has a gate register and a status register at low offsets.

Write data carries no information, so the port has an address, a write strobe, a read strobe and read data only.

Top module: `irq_gate_ctrl`

## Requirements
- R1: While reset is low and after it is released, both channels are disarmed. card_irq is 0 and bus_rdata is 0x00, even when the raw lines are high.
- R2: A write to a channel's gate register arms that channel from the next clock edge. In the two-channel build the gate register is at 0x2200 for channel 0 (drv_irq[0]) and at 0x3200 for channel 1 (drv_irq[1]). A write does not affect the other channel.
- R3: A read of a channel's gate register disarms that channel from the next clock edge. The read returns 0x00.
- R4: When bus_wr and bus_rd are both high on a gate register in the same cycle, the write wins and the channel ends up armed.
- R5: After clock edge k, card_irq equals the OR over the channels of (raw line AND armed state), both taken at edge k. The armed state used is the one held before any access at edge k.
- R6: A read of a status register returns the channel's raw line in bit 0 and zeros in bits 7:1, whether the channel is armed or not. The status register is at 0x2290 for channel 0 and at 0x3290 for channel 1. Read data appears in the cycle after the read strobe. In every cycle that does not follow a read, bus_rdata is 0x00.
- R7: irq_pending is high, with no clock delay, whenever any raw line is high, whatever the armed state.
- R8: A write to one gate register followed on the very next cycle by a read of the other gate register leaves only the written channel armed. This holds in both directions.
- R9: Writes to status registers, and accesses to any unmapped address, leave both armed states unchanged. Reads of unmapped addresses return 0x00.
- R10: With NUM_CH = 1, the gate register is at 0x0004 and the status register is at 0x0000. Both behave as described in R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| drv_irq | input | NUM_CH | Raw drive interrupt lines |
| card_irq | output | 1 | Registered gated card interrupt |
| irq_pending | output | 1 | OR of the raw lines |

## Verification
The hardest case to reach from the ports is the routing handover. Here the write that arms one channel and the read that disarms the other land on adjacent clock edges, and a stale armed state would leak out on card_irq for exactly one cycle. The stimulus issues the two accesses back to back in both directions, with both raw lines high. It then toggles each raw line separately, so that each channel's armed state shows on card_irq. A cycle-level model in the bench predicts card_irq, bus_rdata and irq_pending on every clock, so a single stray cycle is caught.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    // Per-channel registered state
    typedef struct packed {
        logic en;
    } gate_st_t;

    // Gate register byte offset for channel ch of an nch-channel build
    function automatic logic [15:0] gate_off(input int nch, input int ch);
        if (nch == 1) return 16'h0004;
        return (ch == 0) ? 16'h2200 : 16'h3200;
    endfunction

    // Status register byte offset for channel ch of an nch-channel build
    function automatic logic [15:0] status_off(input int nch, input int ch);
        if (nch == 1) return 16'h0000;
        return (ch == 0) ? 16'h2290 : 16'h3290;
    endfunction

endpackage

// File: rtl/irqg_channel.sv
module irqg_channel
    import irqg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] GATE_A = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              en
);

    gate_st_t st_d, st_q;
    logic     hit;

    assign hit = (addr == GATE_A);

    always_comb begin
        st_d = st_q;
        if (hit && wr)      st_d.en = 1'b1;   // write wins over a same-cycle read
        else if (hit && rd) st_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == GATE_A) |=> en); // R2

    AST_READ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && addr == GATE_A) |=> !en); // R3

    AST_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != GATE_A || (!wr && !rd)) |=> $stable(en)); // R9

endmodule

// File: rtl/irqg_readback.sv
module irqg_readback
    import irqg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic [NUM_CH-1:0] raw,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rb_st_t;

    rb_st_t            st_d, st_q;
    logic [NUM_CH-1:0] hit_stat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_stat
        assign hit_stat[c] = (addr == ADDR_W'(status_off(NUM_CH, c)));
    end

    always_comb begin
        st_d = '0;
        if (rd) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (hit_stat[c]) st_d.data[0] = raw[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.data;

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0)); // R6

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irqg_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] drv_irq,
    output logic              card_irq,
    output logic              irq_pending
);

    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [NUM_CH-1:0] en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        irqg_channel #(
            .ADDR_W (ADDR_W),
            .GATE_A (ADDR_W'(gate_off(NUM_CH, c)))
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (bus_addr),
            .wr    (bus_wr),
            .rd    (bus_rd),
            .en    (en[c])
        );
    end

    irqg_readback #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rb (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .rd    (bus_rd),
        .raw   (drv_irq),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(drv_irq & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign card_irq    = st_q.irq;
    assign irq_pending = |drv_irq;

    AST_GATES_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !card_irq); // R5

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |=> !card_irq); // R7

endmodule

// File: tb/sim_irq_gate_ctrl.sv
`timescale 1ns/1ps
module sim_irq_gate_ctrl;

    localparam logic [15:0] G0 = 16'h2200, G1 = 16'h3200;
    localparam logic [15:0] S0 = 16'h2290, S1 = 16'h3290;
    localparam logic [15:0] GS = 16'h0004, SS = 16'h0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  raw = 2'b00;
    logic [7:0]  rdata, rdata1;
    logic        irq, pend, irq1, pend1;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0, done = 0;

    always #5 clk = ~clk;

    irq_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_rdata(rdata), .drv_irq(raw), .card_irq(irq), .irq_pending(pend)
    );

    irq_gate_ctrl #(.NUM_CH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_rdata(rdata1), .drv_irq(raw[0:0]), .card_irq(irq1), .irq_pending(pend1)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    bit [1:0] m_en;
    bit       m1_en;
    bit       e_irq, e1_irq;
    bit [7:0] e_rd, e1_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m1_en = 0; e_irq = 0; e1_irq = 0; e_rd = 0; e1_rd = 0;
        end else begin
            e_irq  = (raw[0] & m_en[0]) | (raw[1] & m_en[1]);
            e1_irq = raw[0] & m1_en;
            e_rd = 0; e1_rd = 0;
            if (rd) begin
                if (addr == S0) e_rd = {7'd0, raw[0]};
                if (addr == S1) e_rd = {7'd0, raw[1]};
                if (addr == SS) e1_rd = {7'd0, raw[0]};
            end
            if (wr && addr == G0) m_en[0] = 1; else if (rd && addr == G0) m_en[0] = 0;
            if (wr && addr == G1) m_en[1] = 1; else if (rd && addr == G1) m_en[1] = 0;
            if (wr && addr == GS) m1_en = 1;   else if (rd && addr == GS) m1_en = 0;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R5", "card_irq vs model", {7'd0, irq}, {7'd0, e_irq});
            chk("R6", "rdata vs model", rdata, e_rd);
            chk("R7", "irq_pending", {7'd0, pend}, {7'd0, |raw});
            chk("R10", "single card_irq vs model", {7'd0, irq1}, {7'd0, e1_irq});
            chk("R10", "single rdata vs model", rdata1, e1_rd);
        end
    end

    // One access: strobes high for exactly one clock edge
    task automatic acc(input bit w, input bit r, input logic [15:0] a);
        @(posedge clk); #1;
        addr = a; wr = w; rd = r;
        @(posedge clk); #1;
        wr = 0; rd = 0; addr = 16'h1111;
    endtask

    // Let card_irq catch up with the current state, then sample
    task automatic settle();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    initial begin
        raw = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "card_irq in reset", {7'd0, irq}, 8'd0);
        chk("R1", "rdata in reset", rdata, 8'd0);
        chk("R1", "single card_irq in reset", {7'd0, irq1}, 8'd0);
        @(posedge clk); #1; rst_n = 1; cmp_on = 1;
        settle();
        chk("R1", "card_irq after reset, raw high", {7'd0, irq}, 8'd0);

        // R2: arm channel 0 only
        raw = 2'b01;
        acc(1, 0, G0);
        settle();
        chk("R2", "ch0 armed", {7'd0, irq}, 8'd1);
        raw = 2'b10;
        settle();
        chk("R2", "ch1 untouched", {7'd0, irq}, 8'd0);

        // R6: status shows raw regardless of gate
        acc(0, 1, S1);
        @(negedge clk);
        chk("R6", "status ch1 while disarmed", rdata, 8'h01);
        raw = 2'b01;
        acc(0, 1, S1);
        @(negedge clk);
        chk("R6", "status ch1 low", rdata, 8'h00);
        acc(0, 1, S0);
        @(negedge clk);
        chk("R6", "status ch0 while armed", rdata, 8'h01);

        // R9: status write and unmapped accesses leave gates alone
        raw = 2'b10;
        acc(1, 0, S1);
        acc(1, 0, 16'h1234);
        acc(0, 1, 16'h2201);
        @(negedge clk);
        chk("R9", "unmapped read data", rdata, 8'h00);
        settle();
        chk("R9", "ch1 still disarmed", {7'd0, irq}, 8'd0);
        raw = 2'b01;
        settle();
        chk("R9", "ch0 still armed", {7'd0, irq}, 8'd1);

        // R3: read of gate disarms, returns zero
        acc(0, 1, G0);
        @(negedge clk);
        chk("R3", "gate read data", rdata, 8'h00);
        settle();
        chk("R3", "ch0 disarmed", {7'd0, irq}, 8'd0);

        // R4: simultaneous write and read arms
        raw = 2'b10;
        acc(1, 1, G1);
        settle();
        chk("R4", "write wins", {7'd0, irq}, 8'd1);

        // R8: route to channel 0 (write G0, read G1 next cycle)
        raw = 2'b11;
        @(posedge clk); #1; addr = G0; wr = 1;
        @(posedge clk); #1; addr = G1; wr = 0; rd = 1;
        @(posedge clk); #1; rd = 0; addr = 16'h1111;
        raw = 2'b10;
        settle();
        chk("R8", "route0: ch1 blocked", {7'd0, irq}, 8'd0);
        raw = 2'b01;
        settle();
        chk("R8", "route0: ch0 passes", {7'd0, irq}, 8'd1);
        // R8: route to channel 1
        raw = 2'b11;
        @(posedge clk); #1; addr = G1; wr = 1;
        @(posedge clk); #1; addr = G0; wr = 0; rd = 1;
        @(posedge clk); #1; rd = 0; addr = 16'h1111;
        raw = 2'b01;
        settle();
        chk("R8", "route1: ch0 blocked", {7'd0, irq}, 8'd0);
        raw = 2'b10;
        settle();
        chk("R8", "route1: ch1 passes", {7'd0, irq}, 8'd1);

        // R7: pending follows raw at once
        raw = 2'b00; #1;
        chk("R7", "pending none", {7'd0, pend}, 8'd0);
        raw = 2'b01; #1;
        chk("R7", "pending ch0", {7'd0, pend}, 8'd1);
        raw = 2'b10; #1;
        chk("R7", "pending ch1", {7'd0, pend}, 8'd1);

        // R10: single-channel variant
        raw = 2'b01;
        acc(1, 0, GS);
        settle();
        chk("R10", "single armed", {7'd0, irq1}, 8'd1);
        acc(0, 1, SS);
        @(negedge clk);
        chk("R10", "single status", rdata1, 8'h01);
        acc(0, 1, GS);
        @(negedge clk);
        chk("R10", "single gate read data", rdata1, 8'h00);
        settle();
        chk("R10", "single disarmed", {7'd0, irq1}, 8'd0);

        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule